// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block drives the direction-enable line of a half-duplex RS-485 transceiver from the transmit side of a UART. When the transmit FIFO holds data, or the shifter is busy, the line is switched to drive mode. It stays there across every frame. A frame is a start bit, eight data bits with the LSB first, a parity bit and a stop bit. Once the final stop bit has left and nothing more is queued, the line stays in drive mode for a programmable number of bit periods. After that it drops back to receive mode.

The hold length comes from an 8-bit value, which may be anything from 0 to 255 bit times. It is captured when the countdown starts. Only baud ticks advance the count. New data during the countdown cancels it without any glitch on the line. A polarity bit selects which logic level means "drive".

The controller is a three-state machine:
- IDLE: receive mode.
- DRIVE: transmitting.
- LINGER: post-frame hold countdown.

It has six transitions:
- IDLE→DRIVE on pending data.
- DRIVE→LINGER on a final stop strobe with a non-zero hold.
- DRIVE→IDLE on a final stop strobe with a zero hold.
- LINGER→DRIVE on new pending data.
- LINGER→LINGER reload on a repeated stop strobe.
- LINGER→IDLE on the baud tick that ends the count.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: During and directly after reset the controller is in receive mode. `dir_out` equals `~pol_inv`.
- R2: From receive mode, `fifo_nonempty`=1 at a clock edge puts `dir_out` at the drive level after that edge. With no pending data, `dir_out` stays at the receive level.
- R3: In drive mode, `dir_out` holds the drive level through all frame bits while `fifo_nonempty` or `shifter_busy` is 1. A `stop_done` strobe that arrives while `fifo_nonempty`=1 does not release it.
- R4: After a `stop_done` strobe with `fifo_nonempty`=0, `shifter_busy`=0 and hold value N>0, `dir_out` keeps the drive level for exactly N more `baud_tick` pulses. It returns to the receive level after the clock edge that samples the Nth pulse.
- R5: With hold value 0, `dir_out` returns to the receive level after the clock edge that samples the final `stop_done` strobe.
- R6: During the hold, clock cycles without `baud_tick` do not advance the countdown.
- R7: `fifo_nonempty` or `shifter_busy` at 1 during the hold cancels the countdown and keeps the drive level with no gap. A later final `stop_done` restarts the full N-tick hold.
- R8: Changes to `hold_bits` during a running countdown do not alter its length. The value sampled with the `stop_done` strobe is used.
- R9: Polarity is selected by `pol_inv`. With `pol_inv`=1 the drive level is 1 and the receive level is 0. With `pol_inv`=0 the drive level is 0 and the receive level is 1.
- R10: When new pending data arrives in the same cycle as the baud tick that would end the hold, the cancel wins and the drive level is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| fifo_nonempty | input | 1 | Transmit FIFO holds data |
| shifter_busy | input | 1 | Transmit shifter is sending a frame |
| stop_done | input | 1 | One-cycle strobe at the end of a stop bit, aligned with `baud_tick` |
| hold_bits | input | 8 | Post-frame hold length in bit periods |
| pol_inv | input | 1 | Polarity select, 1 = drive level is high |
| dir_out | output | 1 | Transceiver direction enable |

## Verification
Two events can fall in the same cycle:
- the pending-data flag can rise on the very baud tick that would end the hold countdown, which is a cancel coinciding with an expiry;
- the stop strobe can arrive while the FIFO is still non-empty, which is an end-of-frame coinciding with new data.

The bench provokes both by driving `fifo_nonempty` high exactly on the expiring tick and on the stop tick. It then judges that the line stays at the drive level on the next cycle and afterwards. For the expiry collision it also checks that a later stop strobe starts a fresh full-length hold.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

    // Controller modes
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // receive mode
        ST_DRIVE  = 2'd1,   // transmitting frames
        ST_LINGER = 2'd2    // post-frame hold countdown
    } dir_state_e;

endpackage

// File: rtl/rs485_hold_counter.sv
module rs485_hold_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             at_last
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain_q;

    // Loaded value is frozen for the whole countdown; only dec moves it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (dec && remain_q != '0) begin
            remain_q <= remain_q - ONE;
        end
    end

    assign at_last = (remain_q == ONE);

endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
    import rs485_dir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic baud_tick,
    input  logic fifo_nonempty,
    input  logic shifter_busy,
    input  logic stop_done,
    input  logic hold_zero,
    input  logic cnt_last,
    output logic cnt_load,
    output logic cnt_dec,
    output logic drive_on
);

    dir_state_e state_q;
    dir_state_e state_d;
    logic       pending;
    logic       final_stop;

    assign pending    = fifo_nonempty | shifter_busy;
    assign final_stop = stop_done & ~pending;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state and counter control
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pending) begin
                    state_d = ST_DRIVE;
                end
            end
            ST_DRIVE: begin
                if (final_stop) begin
                    if (hold_zero) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d  = ST_LINGER;
                        cnt_load = 1'b1;
                    end
                end
            end
            ST_LINGER: begin
                // Cancel has priority over the expiry tick.
                if (pending) begin
                    state_d = ST_DRIVE;
                end else if (stop_done) begin
                    if (hold_zero) begin
                        state_d = ST_IDLE;
                    end else begin
                        cnt_load = 1'b1;
                    end
                end else if (baud_tick) begin
                    if (cnt_last) begin
                        state_d = ST_IDLE;
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Output decode
    always_comb begin
        drive_on = (state_q != ST_IDLE);
    end

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              fifo_nonempty,
    input  logic              shifter_busy,
    input  logic              stop_done,
    input  logic [HOLD_W-1:0] hold_bits,
    input  logic              pol_inv,
    output logic              dir_out
);

    logic cnt_load;
    logic cnt_dec;
    logic cnt_last;
    logic drive_on;
    logic hold_zero;

    assign hold_zero = (hold_bits == '0);

    rs485_dir_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .baud_tick    (baud_tick),
        .fifo_nonempty(fifo_nonempty),
        .shifter_busy (shifter_busy),
        .stop_done    (stop_done),
        .hold_zero    (hold_zero),
        .cnt_last     (cnt_last),
        .cnt_load     (cnt_load),
        .cnt_dec      (cnt_dec),
        .drive_on     (drive_on)
    );

    rs485_hold_counter #(.CNT_W(HOLD_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(hold_bits),
        .dec     (cnt_dec),
        .at_last (cnt_last)
    );

    // Drive level equals pol_inv; receive level is its complement.
    assign dir_out = drive_on ? pol_inv : ~pol_inv;

endmodule

// File: rtl/rs485_dir_chk.sv
module rs485_dir_chk #(
    parameter int HOLD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              baud_tick,
    input logic              fifo_nonempty,
    input logic              shifter_busy,
    input logic              stop_done,
    input logic [HOLD_W-1:0] hold_bits,
    input logic              pol_inv,
    input logic              dir_out
);

    logic act;
    assign act = (dir_out == pol_inv);

    AST_RESET_RECEIVE: assert property (@(posedge clk) $rose(rst_n) |-> !act); // R1

    AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && fifo_nonempty) |=> act); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && !fifo_nonempty && !shifter_busy) |=> !act); // R2

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (act && (fifo_nonempty || shifter_busy)) |=> act); // R3

    AST_ZERO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (act && stop_done && !fifo_nonempty && !shifter_busy && hold_bits == '0) |=> !act); // R5

    AST_NO_TICK_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !baud_tick && !stop_done) |=> act); // R6

endmodule

bind rs485_dir_ctrl rs485_dir_chk #(.HOLD_W(HOLD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .baud_tick    (baud_tick),
    .fifo_nonempty(fifo_nonempty),
    .shifter_busy (shifter_busy),
    .stop_done    (stop_done),
    .hold_bits    (hold_bits),
    .pol_inv      (pol_inv),
    .dir_out      (dir_out)
);

// File: tb/rs485_dir_ctrl_tb_top.sv
`timescale 1ns/1ps
module rs485_dir_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       fifo_nonempty = 1'b0;
    logic       shifter_busy = 1'b0;
    logic       stop_done = 1'b0;
    logic [7:0] hold_bits = 8'd0;
    logic       pol_inv = 1'b0;
    logic       dir_out;

    int n_checks = 0;
    int n_errors = 0;
    int gap = 2;

    always #2.5 clk = ~clk;

    rs485_dir_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .baud_tick    (baud_tick),
        .fifo_nonempty(fifo_nonempty),
        .shifter_busy (shifter_busy),
        .stop_done    (stop_done),
        .hold_bits    (hold_bits),
        .pol_inv      (pol_inv),
        .dir_out      (dir_out)
    );

    // Expected level: drive level is pol_inv, receive level its complement (R9).
    task automatic expect_act(input bit want_act, input string req);
        logic exp;
        exp = want_act ? pol_inv : ~pol_inv;
        n_checks++;
        if (dir_out !== exp) begin
            n_errors++;
            $display("FAIL %s: dir_out=%b expected %b at %0t", req, dir_out, exp, $time);
        end
    endtask

    task automatic idle_cycles(input int n, input bit want_act, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            expect_act(want_act, req);
        end
    endtask

    // One baud tick; the sample is taken one negedge later, after the capturing edge.
    task automatic tick(input bit with_stop);
        @(negedge clk);
        baud_tick = 1'b1;
        stop_done = with_stop;
        if (with_stop) shifter_busy = 1'b0;
        @(negedge clk);
        baud_tick = 1'b0;
        stop_done = 1'b0;
    endtask

    // Send one 11-bit frame; the FIFO empties as the shifter loads.
    task automatic send_frame(input bit more_after);
        @(negedge clk);
        fifo_nonempty = 1'b1;
        @(negedge clk);
        expect_act(1'b1, "R2");
        shifter_busy = 1'b1;
        fifo_nonempty = more_after;
        for (int b = 0; b < 10; b++) begin
            idle_cycles(gap, 1'b1, "R3");
            tick(1'b0);
            expect_act(1'b1, "R3");
        end
        idle_cycles(gap, 1'b1, "R3");
    endtask

    task automatic run_hold(input int n, input bit inv);
        pol_inv = inv;
        hold_bits = 8'(n);
        idle_cycles(2, 1'b0, "R9");
        send_frame(1'b0);
        tick(1'b1);
        expect_act(n != 0, n == 0 ? "R5" : "R4");
        for (int k = 1; k <= n; k++) begin
            if (k == 1) hold_bits = 8'(n + 3);   // R8: changed mid-countdown
            idle_cycles(gap, 1'b1, "R6");
            tick(1'b0);
            expect_act(k < n, k < n ? "R4" : "R8");
        end
        idle_cycles(3, 1'b0, "R4");
    endtask

    initial begin
        pol_inv = 1'b0;
        repeat (3) @(negedge clk);
        expect_act(1'b0, "R1");
        rst_n = 1'b1;
        idle_cycles(3, 1'b0, "R1");

        // Sweep of hold lengths, both polarities, two tick spacings (R4, R5, R6, R9)
        for (int inv = 0; inv < 2; inv++) begin
            for (int n = 0; n <= 9; n++) begin
                gap = (n % 2) + 1;
                run_hold(n, inv[0]);
            end
        end
        gap = 0;
        run_hold(255, 1'b1);
        gap = 2;

        // Stop strobe with FIFO still non-empty does not release (R3)
        pol_inv = 1'b1;
        hold_bits = 8'd0;
        send_frame(1'b1);
        tick(1'b1);
        expect_act(1'b1, "R3");
        shifter_busy = 1'b1;
        fifo_nonempty = 1'b0;
        idle_cycles(2, 1'b1, "R3");
        tick(1'b1);
        expect_act(1'b0, "R5");

        // Cancel mid-countdown, then a fresh full hold (R7)
        hold_bits = 8'd5;
        send_frame(1'b0);
        tick(1'b1);
        tick(1'b0);
        tick(1'b0);
        @(negedge clk);
        fifo_nonempty = 1'b1;
        @(negedge clk);
        expect_act(1'b1, "R7");
        fifo_nonempty = 1'b0;
        shifter_busy = 1'b1;
        for (int k = 0; k < 6; k++) begin
            tick(1'b0);
            expect_act(1'b1, "R7");
        end
        tick(1'b1);
        for (int k = 1; k <= 5; k++) begin
            tick(1'b0);
            expect_act(k < 5, "R7");
        end

        // Data arrives on the expiring tick (R10)
        hold_bits = 8'd3;
        pol_inv = 1'b0;
        send_frame(1'b0);
        tick(1'b1);
        tick(1'b0);
        tick(1'b0);
        @(negedge clk);
        baud_tick = 1'b1;
        fifo_nonempty = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
        expect_act(1'b1, "R10");
        idle_cycles(3, 1'b1, "R10");
        fifo_nonempty = 1'b0;
        shifter_busy = 1'b1;
        tick(1'b0);
        tick(1'b1);
        for (int k = 1; k <= 3; k++) begin
            tick(1'b0);
            expect_act(k < 3, "R10");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule